// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block is the interrupt front end of a processor. Peripheral devices each drive an active-low request. Every device is tied to one of seven priority levels, from 1 (least urgent) to 7 (most urgent). The block synchronises the requests and merges them into per-level lines. It encodes the highest pending level and compares that level with a 3-bit mask kept for the processor. From the result it drives an interrupt request towards the core. Level 7 ignores the mask.

When the core runs an acknowledge bus cycle, the block does four things. It decodes the acknowledged level into one-hot acknowledge lines. It passes that acknowledge down a daisy chain of device models in index order. It returns the vector number of the first requester at that level, or a default vector if nothing captures it. It presents that vector number multiplied by four as the byte address of the handler pointer. On entry to service it saves the current mask on an internal stack and raises the mask to the acknowledged level. A return-from-interrupt pulse restores the saved mask.

A three-state machine sequences the cycle:
- `S_IDLE` waits for an acknowledge and handles returns.
- `S_VECTOR` resolves the chain.
- `S_HOLD` presents the vector until the bus cycle ends.

The transitions are:
- ACK_SEEN: `S_IDLE` to `S_VECTOR`.
- VECTOR_ISSUED: `S_VECTOR` to `S_HOLD`.
- CYCLE_END: `S_HOLD` to `S_IDLE`.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the mask is 0, `pend_level` is 0, `irq_out` is 0, `vec_valid` is 0, `iack_lines` is 0 and the machine is in `S_IDLE`.
- R2: A device requests by holding its bit of `dev_req_n` low. After a two-flop synchroniser, `pend_level` gives the highest level (1..7) that has a requesting device, or 0 when no device is requesting.
- R3: `irq_out` is 1 exactly when `pend_level` is 7, or when `pend_level` is greater than the current mask. A level equal to or below the mask is blocked.
- R4: An acknowledge is taken only in `S_IDLE`, and only when `cpu_fc` is 3'b111 and `cpu_alvl` (address bits 3..1) is non-zero. Any other function code, and a level of 0, leave the vector outputs and the mask unchanged.
- R5: While in `S_VECTOR`, `iack_lines` has exactly bit (L-1) set for the acknowledged level L. It is 0 in every other state.
- R6: The acknowledge runs through the devices in index order 0 upward. A device that is not requesting at level L passes it on. The first device requesting at L captures it and supplies its vector number from `dev_vec`.
- R7: If no device captures the acknowledge, the vector number is the parameter `DEFAULT_VEC` (default 8'h0F).
- R8: `vec_valid` rises on the second clock edge after the acknowledge is presented. It stays high with `vec_num` and `vec_addr` = `vec_num`*4 (10 bits) until `cpu_fc` leaves 3'b111, and then drops on the next edge.
- R9: Entering service at level L pushes the old mask and sets the mask to L. Requests that are masked stay visible on `pend_level`.
- R10: A one-cycle `rti_pulse` in `S_IDLE` pops the stack and restores the saved mask. On an empty stack the mask stays unchanged. A push onto a full stack is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_req_n | input | NDEV | Active-low request, one per device |
| dev_level | input | 3*NDEV | Priority level of each device, 3 bits per device |
| dev_vec | input | 8*NDEV | Vector number of each device, 8 bits per device |
| cpu_fc | input | 3 | Bus cycle function code; 3'b111 marks an acknowledge |
| cpu_alvl | input | 3 | Acknowledged level (address bits 3..1) |
| rti_pulse | input | 1 | Return-from-interrupt, restores the saved mask |
| pend_level | output | 3 | Highest pending level, 0 if none |
| irq_out | output | 1 | Unmasked interrupt request to the core |
| mask_level | output | 3 | Current interrupt mask |
| iack_lines | output | 7 | Decoded acknowledge, bit L-1 for level L |
| vec_valid | output | 1 | Vector outputs are valid |
| vec_num | output | 8 | Captured vector number |
| vec_addr | output | 10 | Vector-table byte address (vector times four) |

## Verification
The bench targets the following corner cases:
- A chain where the first device at the acknowledged level is idle and a later one captures. A chain that ignores position would return the wrong vector.
- Two devices requesting at the same level. A wrong priority order would grant the later device.
- An acknowledge at a level with no requester. A design without the default would present stale data.
- A pending request that is masked at an equal level. It must stay visible but must not raise the request.
- Level 7 while the mask is already 7.
- Function codes that are not an acknowledge, and a level of 0.
- A chain of nested returns followed by one return too many. A stack off by one would restore the wrong mask.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int LVL_W   = 3;
    localparam int N_LVL   = 7;
    localparam int VEC_W   = 8;
    localparam int VADDR_W = VEC_W + 2;
    localparam logic [2:0] FC_IACK = 3'b111;
    localparam logic [LVL_W-1:0] TOP_LVL = 3'd7;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_VECTOR = 2'd1,
        S_HOLD   = 2'd2
    } ack_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_n,
    output logic [WIDTH-1:0] sync_n
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
        end else begin
            stage_q[0] <= async_n;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_n = stage_q[STAGES-1];
endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
    import irq_vec_pkg::*;
#(
    parameter int NDEV = 4
) (
    input  logic [NDEV-1:0]       req,
    input  logic [LVL_W*NDEV-1:0] dev_level,
    input  logic [LVL_W-1:0]      mask,
    output logic [LVL_W-1:0]      pend,
    output logic                  take
);
    logic [N_LVL:1] line_n;

    always_comb begin
        line_n = '1;
        for (int d = 0; d < NDEV; d++) begin
            for (int l = 1; l <= N_LVL; l++) begin
                if (req[d] && (dev_level[d*LVL_W +: LVL_W] == LVL_W'(l)))
                    line_n[l] = 1'b0;
            end
        end
    end

    always_comb begin
        pend = '0;
        for (int l = 1; l <= N_LVL; l++) begin
            if (!line_n[l]) pend = LVL_W'(l);
        end
    end

    always_comb begin
        take = 1'b0;
        if (pend == TOP_LVL)   take = 1'b1;
        else if (pend > mask)  take = 1'b1;
    end
endmodule

// File: rtl/iack_chain.sv
module iack_chain
    import irq_vec_pkg::*;
#(
    parameter int NDEV = 4,
    parameter logic [VEC_W-1:0] DEFAULT_VEC = 8'h0F
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ack_en,
    input  logic [LVL_W-1:0]      ack_lvl,
    input  logic [NDEV-1:0]       req,
    input  logic [LVL_W*NDEV-1:0] dev_level,
    input  logic [VEC_W*NDEV-1:0] dev_vec,
    output logic [N_LVL-1:0]      iack,
    output logic [NDEV-1:0]       grant,
    output logic [VEC_W-1:0]      vec
);
    logic [NDEV:0] carry;

    always_comb begin
        iack = '0;
        if (ack_en && ack_lvl != '0) iack[ack_lvl - 3'd1] = 1'b1;
    end

    assign carry[0] = ack_en;

    for (genvar d = 0; d < NDEV; d++) begin : g_dev
        logic wants;
        assign wants      = req[d] && (dev_level[d*LVL_W +: LVL_W] == ack_lvl);
        assign grant[d]   = carry[d] && wants;
        assign carry[d+1] = carry[d] && !wants;
    end

    always_comb begin
        vec = DEFAULT_VEC;
        for (int d = NDEV - 1; d >= 0; d--) begin
            if (grant[d]) vec = dev_vec[d*VEC_W +: VEC_W];
        end
    end

    // R6: at most one device captures the acknowledge
    assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R5: acknowledge lines only carry one level
    assert_iack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(iack));
endmodule

// File: rtl/mask_stack.sv
module mask_stack
    import irq_vec_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter,
    input  logic [LVL_W-1:0] enter_lvl,
    input  logic             leave,
    output logic [LVL_W-1:0] mask
);
    localparam int PTR_W = $clog2(DEPTH + 1);

    logic [LVL_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] sp_q;
    logic             full, empty;

    assign full  = (sp_q == PTR_W'(DEPTH));
    assign empty = (sp_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '0;
            mask <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (enter) begin
            mask <= enter_lvl;
            if (!full) begin
                mem_q[sp_q] <= mask;
                sp_q        <= sp_q + 1'b1;
            end
        end else if (leave && !empty) begin
            mask <= mem_q[sp_q - 1'b1];
            sp_q <= sp_q - 1'b1;
        end
    end

    // R10: stack pointer never leaves its range
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sp_q <= PTR_W'(DEPTH));
    // R10: a return on an empty stack keeps the mask
    assert_empty_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (leave && !enter && empty) |=> $stable(mask));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter int NDEV = 4,
    parameter int STACK_DEPTH = 8,
    parameter logic [7:0] DEFAULT_VEC = 8'h0F
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NDEV-1:0] dev_req_n,
    input  logic [3*NDEV-1:0] dev_level,
    input  logic [8*NDEV-1:0] dev_vec,
    input  logic [2:0]      cpu_fc,
    input  logic [2:0]      cpu_alvl,
    input  logic            rti_pulse,
    output logic [2:0]      pend_level,
    output logic            irq_out,
    output logic [2:0]      mask_level,
    output logic [6:0]      iack_lines,
    output logic            vec_valid,
    output logic [7:0]      vec_num,
    output logic [9:0]      vec_addr
);
    ack_state_t       state_q, state_d;
    logic [NDEV-1:0]  req_n_s, req;
    logic [LVL_W-1:0] ack_lvl_q;
    logic [VEC_W-1:0] vec_q, chain_vec;
    logic [NDEV-1:0]  grant;
    logic             ack_take, enter, leave;

    irq_sync #(.WIDTH(NDEV), .STAGES(2)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_n(dev_req_n), .sync_n(req_n_s)
    );
    assign req = ~req_n_s;

    irq_level_enc #(.NDEV(NDEV)) i_enc (
        .req(req), .dev_level(dev_level), .mask(mask_level),
        .pend(pend_level), .take(irq_out)
    );

    iack_chain #(.NDEV(NDEV), .DEFAULT_VEC(DEFAULT_VEC)) i_chain (
        .clk(clk), .rst_n(rst_n),
        .ack_en(state_q == S_VECTOR), .ack_lvl(ack_lvl_q),
        .req(req), .dev_level(dev_level), .dev_vec(dev_vec),
        .iack(iack_lines), .grant(grant), .vec(chain_vec)
    );

    mask_stack #(.DEPTH(STACK_DEPTH)) i_stack (
        .clk(clk), .rst_n(rst_n), .enter(enter), .enter_lvl(ack_lvl_q),
        .leave(leave), .mask(mask_level)
    );

    assign ack_take = (cpu_fc == FC_IACK) && (cpu_alvl != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            ack_lvl_q <= '0;
            vec_q     <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && ack_take) ack_lvl_q <= cpu_alvl;
            if (state_q == S_VECTOR)            vec_q     <= chain_vec;
        end
    end

    always_comb begin
        state_d = state_q;
        enter   = 1'b0;
        leave   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (ack_take)       state_d = S_VECTOR;
                else if (rti_pulse) leave   = 1'b1;
            end
            S_VECTOR: begin
                enter   = 1'b1;
                state_d = S_HOLD;
            end
            S_HOLD: begin
                if (cpu_fc != FC_IACK) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign vec_valid = (state_q == S_HOLD);
    assign vec_num   = vec_q;
    assign vec_addr  = {vec_q, 2'b00};

    // R9: entering service sets the mask to the acknowledged level
    assert_mask_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_VECTOR) |=> (mask_level == $past(ack_lvl_q)));
    // R3: level 7 always reaches the core
    assert_top_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_level == 3'd7) |-> irq_out);
    // R3: a request at or below the mask is held back
    assert_mask_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_level != 3'd7 && pend_level <= mask_level) |-> !irq_out);
    // R8: the vector stays stable while presented
    assert_vec_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && $past(vec_valid)) |-> $stable(vec_num));
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
    localparam int NDEV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NDEV-1:0] dev_req_n = '1;
    logic [3*NDEV-1:0] dev_level = {3'd7, 3'd3, 3'd5, 3'd3};
    logic [8*NDEV-1:0] dev_vec   = {8'h43, 8'h42, 8'h41, 8'h40};
    logic [2:0] cpu_fc = 3'b000, cpu_alvl = 3'd0;
    logic rti_pulse = 1'b0;
    logic [2:0] pend_level, mask_level;
    logic irq_out, vec_valid;
    logic [6:0] iack_lines;
    logic [7:0] vec_num;
    logic [9:0] vec_addr;

    int checks = 0, errors = 0;
    logic [20:0] exp_q [$];
    logic was_valid = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_vector_ctrl #(.NDEV(NDEV)) i_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .dev_req_n(dev_req_n), .dev_level(dev_level),
        .dev_vec(dev_vec), .cpu_fc(cpu_fc), .cpu_alvl(cpu_alvl),
        .rti_pulse(rti_pulse), .pend_level(pend_level), .irq_out(irq_out),
        .mask_level(mask_level), .iack_lines(iack_lines), .vec_valid(vec_valid),
        .vec_num(vec_num), .vec_addr(vec_addr)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard when a vector is presented (R6 R7 R8 R9)
    always @(negedge clk) begin
        if (vec_valid && !was_valid) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected vector", 1, 0);
            end else begin
                logic [20:0] e;
                e = exp_q.pop_front();
                check("R6/R7 vec_num", vec_num, e[20:13]);
                check("R8 vec_addr", vec_addr, e[12:3]);
                check("R9 mask", mask_level, e[2:0]);
            end
        end
        was_valid <= vec_valid;
    end

    task automatic do_ack(input logic [2:0] lvl, input logic [7:0] exp_vec);
        exp_q.push_back({exp_vec, {exp_vec, 2'b00}, lvl});
        @(negedge clk);
        cpu_fc = 3'b111; cpu_alvl = lvl;
        @(negedge clk);
        check("R5 iack_lines", iack_lines, 7'(1) << (lvl - 1));
        check("R8 vec_valid early", vec_valid, 0);
        @(negedge clk);
        check("R8 vec_valid", vec_valid, 1);
        cpu_fc = 3'b000; cpu_alvl = 3'd0;
        @(negedge clk);
        check("R8 vec_valid drop", vec_valid, 0);
        check("R5 iack idle", iack_lines, 0);
    endtask

    task automatic do_rti(input logic [2:0] exp_mask);
        @(negedge clk);
        rti_pulse = 1'b1;
        @(negedge clk);
        rti_pulse = 1'b0;
        check("R10 restored mask", mask_level, exp_mask);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 mask", mask_level, 0);
        check("R1 pend", pend_level, 0);
        check("R1 irq_out", irq_out, 0);
        check("R1 vec_valid", vec_valid, 0);
        check("R1 iack", iack_lines, 0);

        // R2: device 2 at level 3
        dev_req_n[2] = 1'b0;
        settle();
        check("R2 pend", pend_level, 3);
        check("R3 irq_out", irq_out, 1);

        // R6: device 0 idle passes, device 2 captures
        do_ack(3'd3, 8'h42);
        do_rti(3'd0);

        // R6: two requesters at level 3, device 0 first
        dev_req_n[0] = 1'b0;
        settle();
        do_ack(3'd3, 8'h40);
        // R9: masked request stays pending; R3 equal level blocked
        check("R9 pend kept", pend_level, 3);
        check("R3 blocked", irq_out, 0);

        // R2 highest level wins
        dev_req_n[1] = 1'b0;
        settle();
        check("R2 pend 5", pend_level, 5);
        check("R3 above mask", irq_out, 1);
        do_ack(3'd5, 8'h41);

        dev_req_n[3] = 1'b0;
        settle();
        do_ack(3'd7, 8'h43);
        check("R3 level 7 unmaskable", irq_out, 1);
        check("R2 pend 7", pend_level, 7);

        // R7: no device at level 6
        do_ack(3'd6, 8'h0F);

        // R4: non-acknowledge function code and level 0
        @(negedge clk);
        cpu_fc = 3'b101; cpu_alvl = 3'd2;
        repeat (3) @(negedge clk);
        check("R4 wrong fc valid", vec_valid, 0);
        check("R4 wrong fc iack", iack_lines, 0);
        cpu_fc = 3'b111; cpu_alvl = 3'd0;
        repeat (3) @(negedge clk);
        check("R4 level 0 valid", vec_valid, 0);
        check("R4 mask kept", mask_level, 6);
        cpu_fc = 3'b000;
        @(negedge clk);

        // R10 nested returns then one extra
        do_rti(3'd7);
        do_rti(3'd5);
        do_rti(3'd3);
        do_rti(3'd0);
        do_rti(3'd0);

        dev_req_n = '1;
        settle();
        check("R2 released", pend_level, 0);
        check("R3 released", irq_out, 0);
        check("R8 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule